// File: doc/BRIEF.md
# Response Channel Ready Throttler

This block generates the manager-side ready signals for the two AXI response-direction channels: write response (B) and read data (R). Each ready is held back by a programmable number of clock cycles, so a bench or a system model can emulate a slow consumer. Each channel has its own delay input. A single mode input selects where the count begins.

In the valid-anchored mode (mode 0), the count starts when VALID is first seen high, and ready follows once VALID has been present for the programmed number of cycles. In the handshake-anchored mode (mode 1), the count starts right after the previous handshake on that channel, so ready may already be high before VALID arrives. Every read beat is its own phase. The last-beat flag is accepted but does not change the rule.

Delay and mode are captured per channel only at a phase boundary. A change on the inputs therefore never stretches or shortens a count that is already running. After reset, the captured settings are delay 2 and mode 0.

Top module: `resp_ready_throttle`

## Requirements
- R1: While rstN is low, bReady and rReady are both 0.
- R2: In mode 0 (modeSel = 0), with delay D > 0, ready is 0 in the first D cycles in which VALID is high in a phase and rises in the next cycle, numbering the first VALID cycle as cycle 0.
- R3: In mode 0 with delay 0, ready is 1 in the same cycle in which VALID is first high.
- R4: Once ready is 1, it stays 1 until a handshake (VALID and ready both 1). In the cycle after a handshake, the count restarts from zero for the next phase, so ready is 0 there unless the new delay is 0.
- R5: In mode 1 (modeSel = 1), ready rises D cycles after the cycle that follows a handshake, whether or not VALID is high. With D = 0, ready is 1 in the cycle right after a handshake, which allows back-to-back transfers.
- R6: In mode 1 with VALID low from reset, ready rises in cycle D+1, numbering the first cycle after reset release as cycle 0.
- R7: The B channel uses bDelay and the R channel uses rDelay, independently. Both channels follow the shared modeSel.
- R8: Each R beat is a separate phase. rLast has no effect on rReady.
- R9: Delay and mode are captured only on a handshake, or in mode 0 in a cycle with VALID low. A change while a phase is counting does not alter that phase.
- R10: Until the first capture after reset, a channel uses delay 2 in mode 0. A VALID present in the first cycle after reset therefore sees ready in its third cycle, whatever the delay and mode inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0: count from VALID; 1: count from the previous handshake |
| bDelay | input | DLY_W | Ready delay for the write-response channel |
| rDelay | input | DLY_W | Ready delay for the read-data channel |
| bValid | input | 1 | Write-response VALID |
| rValid | input | 1 | Read-data VALID |
| rLast | input | 1 | Last beat of a read burst (no effect on timing) |
| bReady | output | 1 | Throttled write-response ready |
| rReady | output | 1 | Throttled read-data ready |

## Verification
Two functions can fall on the same clock edge: completing a handshake and capturing a new delay and mode for the next phase. The bench changes the delay inputs in the very cycle of a handshake, including a switch to delay 0 and from one mode to the other. It then judges whether the following phase, often back-to-back with VALID still high, uses the values present at that handshake. A second collision, a mid-phase delay change that arrives while a count is running, is provoked and judged by checking that ready still appears at the originally captured count.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

  // Strobes from a channel controller to its counter datapath
  typedef struct packed {
    logic load;   // capture delay and mode for the next phase
    logic clear;  // restart the count at zero
    logic inc;    // advance the count by one
  } ctlStrobes_t;

  localparam int NUM_CH = 2;  // index 0: write response, 1: read data

endpackage

// File: rtl/throttle_dp.sv
module throttle_dp
  import throttle_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int RST_DLY = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [DLY_W-1:0] delayIn,
  input  logic             modeIn,
  output logic             cntReached,
  output logic             dlyZero,
  output logic             modeQ
);

  localparam logic [DLY_W-1:0] RST_VAL = DLY_W'(RST_DLY);

  logic [DLY_W-1:0] dlyQ;
  logic [DLY_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyQ  <= RST_VAL;
      modeQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      if (strobes.load) begin
        dlyQ  <= delayIn;
        modeQ <= modeIn;
      end
      if (strobes.clear)
        cntQ <= '0;
      else if (strobes.inc)
        cntQ <= cntQ + 1'b1;
    end
  end

  assign cntReached = (cntQ >= dlyQ);
  assign dlyZero    = (dlyQ == '0);

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= dlyQ);

endmodule

// File: rtl/throttle_ctrl.sv
module throttle_ctrl
  import throttle_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        valid,
  input  logic        cntReached,
  input  logic        dlyZero,
  input  logic        modeQ,
  output logic        ready,
  output ctlStrobes_t strobes
);

  logic hs;
  logic phaseIdle;

  always_comb begin
    phaseIdle     = !modeQ && !valid;
    ready         = rstN && (modeQ ? cntReached : (valid && cntReached));
    hs            = valid && ready;
    strobes.load  = hs || phaseIdle;
    strobes.clear = hs || phaseIdle;
    strobes.inc   = !(hs || phaseIdle) && !cntReached && (modeQ || valid);
  end

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !valid) |=> ready);

  // R4
  hs_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && ready) |=> (!ready || dlyZero));

  // R2
  rise_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ready) && !modeQ && !dlyZero) |-> $past(valid));

endmodule

// File: rtl/resp_ready_throttle.sv
module resp_ready_throttle
  import throttle_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int RST_DLY = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeSel,
  input  logic [DLY_W-1:0] bDelay,
  input  logic [DLY_W-1:0] rDelay,
  input  logic             bValid,
  input  logic             rValid,
  input  logic             rLast,
  output logic             bReady,
  output logic             rReady
);

  logic [NUM_CH-1:0] validV;
  logic [NUM_CH-1:0] readyV;
  logic [DLY_W-1:0]  delayV [NUM_CH];

  assign validV    = {rValid, bValid};
  assign delayV[0] = bDelay;
  assign delayV[1] = rDelay;
  assign bReady    = readyV[0];
  assign rReady    = readyV[1];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ctlStrobes_t strobes;
    logic cntReached;
    logic dlyZero;
    logic modeQ;

    throttle_ctrl i_ctrl (
      .clk        (clk),
      .rstN       (rstN),
      .valid      (validV[ch]),
      .cntReached (cntReached),
      .dlyZero    (dlyZero),
      .modeQ      (modeQ),
      .ready      (readyV[ch]),
      .strobes    (strobes)
    );

    throttle_dp #(.DLY_W(DLY_W), .RST_DLY(RST_DLY)) i_dp (
      .clk        (clk),
      .rstN       (rstN),
      .strobes    (strobes),
      .delayIn    (delayV[ch]),
      .modeIn     (modeSel),
      .cntReached (cntReached),
      .dlyZero    (dlyZero),
      .modeQ      (modeQ)
    );
  end

  // R1
  always_comb begin
    if (!rstN) begin
      reset_low_chk: assert (!bReady && !rReady);
    end
  end

  // R8
  last_beat_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rReady && rLast && !modeSel && rDelay != '0) |=> !rReady);

endmodule

// File: tb/test_resp_ready_throttle.sv
module test_resp_ready_throttle;

  localparam int DLY_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0;
  logic [DLY_W-1:0] bDelay = '0;
  logic [DLY_W-1:0] rDelay = '0;
  logic bValid = 1'b0;
  logic rValid = 1'b0;
  logic rLast = 1'b0;
  logic bReady;
  logic rReady;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  expB;
    logic  expR;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  always #5 clk = ~clk;

  resp_ready_throttle #(.DLY_W(DLY_W)) i_resp_ready_throttle (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .bDelay  (bDelay),
    .rDelay  (rDelay),
    .bValid  (bValid),
    .rValid  (rValid),
    .rLast   (rLast),
    .bReady  (bReady),
    .rReady  (rReady)
  );

  // Monitor: pops one expected item per driven cycle, mid-cycle
  always @(negedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      total++;
      if (bReady !== it.expB) begin
        bad++;
        $display("FAIL %s bReady actual=%b expected=%b t=%0t", it.tag, bReady, it.expB, $time);
      end
      total++;
      if (rReady !== it.expR) begin
        bad++;
        $display("FAIL %s rReady actual=%b expected=%b t=%0t", it.tag, rReady, it.expR, $time);
      end
    end
  end

  // Driver: one call = one clock cycle of stimulus plus its expectation
  task automatic step(input logic rst, input logic vb, input logic vr, input logic lst,
                      input logic md, input int db, input int dr,
                      input logic eb, input logic er, input string tag);
    expItem_t it;
    @(negedge clk);
    rstN    = rst;
    bValid  = vb;
    rValid  = vr;
    rLast   = lst;
    modeSel = md;
    bDelay  = DLY_W'(db);
    rDelay  = DLY_W'(dr);
    it.expB = eb;
    it.expR = er;
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  initial begin
    // r1_ reset: outputs low even with delay 0 inputs
    step(0, 1, 1, 0, 1, 0, 0, 0, 0, "R1");
    step(0, 1, 1, 0, 1, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 5, 5, 0, 0, "R1");
    // c0..c2: B valid at once after reset -> default delay 2, mode 0 (R10)
    step(1, 1, 0, 0, 1, 5, 5, 0, 0, "R10");
    step(1, 1, 0, 0, 1, 5, 5, 0, 0, "R10");
    step(1, 1, 0, 0, 1, 5, 5, 1, 0, "R10");
    // c3..c8: mode 1, B counts from its handshake, R from reset (R5, R6)
    step(1, 0, 0, 0, 1, 5, 5, 0, 0, "R5");
    step(1, 0, 0, 0, 1, 5, 5, 0, 0, "R6");
    step(1, 0, 0, 0, 1, 5, 5, 0, 0, "R6");
    step(1, 0, 0, 0, 1, 5, 5, 0, 1, "R6");
    step(1, 0, 0, 0, 1, 5, 5, 0, 1, "R4");
    step(1, 0, 0, 0, 1, 5, 5, 1, 1, "R5");
    // c9: both handshake; new delays captured on this edge (R7)
    step(1, 1, 1, 0, 1, 0, 1, 1, 1, "R7");
    // c10: B delay 0 back-to-back, R delay 1 not yet
    step(1, 1, 1, 0, 1, 0, 1, 1, 0, "R5");
    // c11: B ready without valid, R last beat handshake
    step(1, 0, 1, 1, 1, 0, 1, 1, 1, "R8");
    step(1, 0, 0, 0, 1, 0, 1, 1, 0, "R4");
    step(1, 0, 0, 0, 1, 0, 1, 1, 1, "R5");
    // c14: handshake both, switch to mode 0 with delays 2 and 3 (R9)
    step(1, 1, 1, 0, 0, 2, 3, 1, 1, "R9");
    step(1, 0, 0, 0, 0, 2, 3, 0, 0, "R4");
    // c16..c19: mode 0 counts from valid, independent delays (R2, R7)
    step(1, 1, 1, 0, 0, 2, 3, 0, 0, "R2");
    step(1, 1, 1, 0, 0, 2, 3, 0, 0, "R2");
    step(1, 1, 1, 0, 0, 2, 3, 1, 0, "R7");
    step(1, 0, 1, 0, 0, 2, 3, 0, 1, "R2");
    // c20..c23: next R beat is its own phase; rLast changes nothing (R8)
    step(1, 0, 1, 0, 0, 2, 3, 0, 0, "R8");
    step(1, 0, 1, 1, 0, 2, 3, 0, 0, "R8");
    step(1, 0, 1, 1, 0, 2, 3, 0, 0, "R8");
    step(1, 0, 1, 1, 0, 2, 3, 0, 1, "R8");
    step(1, 0, 0, 0, 0, 2, 3, 0, 0, "R4");
    // c25..c27: B delay changed mid-phase is ignored (R9)
    step(1, 1, 0, 0, 0, 2, 3, 0, 0, "R9");
    step(1, 1, 0, 0, 0, 0, 3, 0, 0, "R9");
    step(1, 1, 0, 0, 0, 0, 3, 1, 0, "R9");
    // c28..c30: delay 0 in mode 0 gives ready with first valid (R3)
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 1, 0, 0, 0, 0, 1, 1, "R3");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule